// File: doc/BRIEF.md
# Key-Locked Indexed Watchdog Configuration

This block is a watchdog timer whose settings sit behind a two-port indirect configuration space: one port selects a register index, the other carries the data. The space is shut after reset. Host software opens it by writing a fixed key byte to the index port on two back-to-back index writes. It then selects the watchdog page through a page-select register, addresses the enable, count-unit, counter and activity-reload registers, and finally closes the space with a separate close key.

Once enabled with a non-zero count, the 8-bit counter steps down by one on each tick of the selected time base: seconds or minutes. The two tick strobes come from outside the block. When the count runs out, the block emits a single-cycle timeout pulse and holds at zero. Keyboard or mouse activity pulses can each be allowed to restore the counter to the last value the host wrote. The block has one write strobe. The data port read value is presented combinationally and has no side effects.

Top module: `keyed_wdog`

## Requirements
- R1: After a synchronous reset the space is shut, the page select is 0x00, the enable, count-unit and activity-reload bits are 0, the count is 0 and `wd_timeout` is low. While the space is not open, `cfg_rdata` reads 0xFF.
- R2: Two consecutive index-port writes of 0x87 open the space. Any other index write after the first 0x87 restarts the key detection, so 0x87, then another value, then 0x87 leaves the space shut.
- R3: An index write of 0xAA while open shuts the space and clears the page select. Configuration values are kept across the shut.
- R4: Data-port writes made while the space is shut change no register.
- R5: Index 0x07 holds the page select and reads back from any page. The watchdog registers respond only when the page is 0x08. Otherwise they read 0x00 and ignore writes.
- R6: Index 0x30 bit 0 is the enable, and 1 means running. It reads back in bit 0, with the other bits 0.
- R7: Index 0xF5 bit 3 selects the unit: 0 counts `tick_sec`, 1 counts `tick_min`. The unselected tick has no effect.
- R8: Writing index 0xF6 loads both the counter and the reload value. Reading index 0xF6 returns the live count. Each selected tick while enabled and non-zero lowers the count by exactly one.
- R9: A tick that takes the count from 1 to 0 raises `wd_timeout` for exactly one cycle, in the cycle after that tick. The count then stays at 0 and further ticks raise no pulse.
- R10: Writing 0 to index 0xF6 stops the count without any timeout pulse.
- R11: Index 0xF7 bit 6 lets a `kbd_act` pulse restore the counter to the reload value, and bit 7 does the same for `mouse_act`. This applies only while enabled and non-zero. An activity whose bit is clear has no effect.
- R12: In the same cycle, a host write of index 0xF6 takes priority over an activity reload, and an activity reload takes priority over a tick. A reload that coincides with the final tick produces no timeout.
- R13: While the enable is 0, ticks and activity leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the selected port |
| cfg_sel | input | 1 | Port select: 0 index port, 1 data port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Data-port read value for the current index |
| tick_sec | input | 1 | One-cycle seconds time-base strobe |
| tick_min | input | 1 | One-cycle minutes time-base strobe |
| kbd_act | input | 1 | Keyboard activity pulse |
| mouse_act | input | 1 | Mouse activity pulse |
| wd_timeout | output | 1 | One-cycle pulse when the count expires |

## Verification
The activity reload and the tick decrement can land on the same clock edge. This matters most when the count is 1, where the tick alone would expire the counter. The bench drives a minutes tick and an enabled mouse pulse in one cycle at count 1. It expects the reload value back and no timeout pulse in the timeout pulse count. It then drives a host write of the counter in the same cycle as both, and expects the written value to win.

// File: rtl/wdcfg_pkg.sv
package wdcfg_pkg;

    localparam int BUS_W = 8;

    // key bytes written to the index port
    localparam logic [BUS_W-1:0] KEY_OPEN  = 8'h87;
    localparam logic [BUS_W-1:0] KEY_CLOSE = 8'hAA;

    // register indices
    localparam logic [BUS_W-1:0] IX_PAGE   = 8'h07;
    localparam logic [BUS_W-1:0] PAGE_WD   = 8'h08;
    localparam logic [BUS_W-1:0] IX_ENABLE = 8'h30;
    localparam logic [BUS_W-1:0] IX_UNIT   = 8'hF5;
    localparam logic [BUS_W-1:0] IX_COUNT  = 8'hF6;
    localparam logic [BUS_W-1:0] IX_ACT    = 8'hF7;

    // field positions
    localparam int EN_BIT    = 0;
    localparam int UNIT_BIT  = 3;
    localparam int KBD_BIT   = 6;
    localparam int MOUSE_BIT = 7;

    localparam logic [BUS_W-1:0] RD_SHUT = 8'hFF;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic enable;
        logic unit_min;
        logic kbd_reload;
        logic mouse_reload;
    } wd_cfg_t;

    function automatic logic pick_tick(wd_cfg_t c, logic ts, logic tm);
        return c.unit_min ? tm : ts;
    endfunction

    function automatic logic act_hit(wd_cfg_t c, logic kb, logic ms);
        return (c.kbd_reload & kb) | (c.mouse_reload & ms);
    endfunction

endpackage

// File: rtl/wdcfg_keylock.sv
module wdcfg_keylock
    import wdcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_wr_i,
    input  logic             data_wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic             open_o,
    output logic [BUS_W-1:0] idx_o,
    output logic [BUS_W-1:0] page_o,
    output logic             page_ok_o
);

    lock_state_e      st_q;
    logic [BUS_W-1:0] idx_q;
    logic [BUS_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LK_SHUT;
            idx_q  <= '0;
            page_q <= '0;
        end else begin
            if (idx_wr_i) begin
                case (st_q)
                    LK_SHUT: st_q <= (wdata_i == KEY_OPEN) ? LK_HALF : LK_SHUT;
                    LK_HALF: st_q <= (wdata_i == KEY_OPEN) ? LK_OPEN : LK_SHUT;
                    LK_OPEN: begin
                        if (wdata_i == KEY_CLOSE) begin
                            st_q   <= LK_SHUT;
                            idx_q  <= '0;
                            page_q <= '0;
                        end else begin
                            idx_q <= wdata_i;
                        end
                    end
                    default: st_q <= LK_SHUT;
                endcase
            end
            if (data_wr_i && st_q == LK_OPEN && idx_q == IX_PAGE) begin
                page_q <= wdata_i;
            end
        end
    end

    assign open_o    = (st_q == LK_OPEN);
    assign idx_o     = idx_q;
    assign page_o    = page_q;
    assign page_ok_o = (page_q == PAGE_WD);

    // R2: the space only opens on the edge of a key write
    assert_unlock_key_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_OPEN && $past(st_q) != LK_OPEN) |-> $past(idx_wr_i && wdata_i == KEY_OPEN));

    // R3: close key shuts the space and drops the page
    assert_close_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (idx_wr_i && st_q == LK_OPEN && wdata_i == KEY_CLOSE) |=> (st_q == LK_SHUT && page_q == '0));

endmodule

// File: rtl/wdcfg_regfile.sv
module wdcfg_regfile
    import wdcfg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             page_ok_i,
    input  logic [BUS_W-1:0] idx_i,
    input  logic [BUS_W-1:0] page_i,
    input  logic             data_wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] count_i,
    output wd_cfg_t          cfg_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic [BUS_W-1:0] rdata_o
);

    wd_cfg_t cfg_q;
    logic    wd_wr;

    assign wd_wr = data_wr_i && open_i && page_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wd_wr) begin
            case (idx_i)
                IX_ENABLE: cfg_q.enable <= wdata_i[EN_BIT];
                IX_UNIT:   cfg_q.unit_min <= wdata_i[UNIT_BIT];
                IX_ACT: begin
                    cfg_q.kbd_reload   <= wdata_i[KBD_BIT];
                    cfg_q.mouse_reload <= wdata_i[MOUSE_BIT];
                end
                default: ;
            endcase
        end
    end

    assign cfg_o      = cfg_q;
    assign load_o     = wd_wr && (idx_i == IX_COUNT);
    assign load_val_o = wdata_i[CNT_W-1:0];

    always_comb begin
        rdata_o = '0;
        if (!open_i) begin
            rdata_o = RD_SHUT;
        end else if (idx_i == IX_PAGE) begin
            rdata_o = page_i;
        end else if (page_ok_i) begin
            case (idx_i)
                IX_ENABLE: rdata_o[EN_BIT] = cfg_q.enable;
                IX_UNIT:   rdata_o[UNIT_BIT] = cfg_q.unit_min;
                IX_COUNT:  rdata_o = BUS_W'(count_i);
                IX_ACT: begin
                    rdata_o[KBD_BIT]   = cfg_q.kbd_reload;
                    rdata_o[MOUSE_BIT] = cfg_q.mouse_reload;
                end
                default: rdata_o = '0;
            endcase
        end
    end

    // R4: nothing changes while the space is shut
    assert_cfg_frozen_shut_R4: assert property (@(posedge clk) disable iff (rst)
        (!open_i) |=> $stable(cfg_q));

    // R5: settings only move after an open, paged data write
    assert_cfg_needs_page_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> $past(data_wr_i && open_i && page_ok_i));

endmodule

// File: rtl/wdcfg_counter.sv
module wdcfg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             act_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             to_q;
    logic             live;

    assign live = en_i && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            to_q  <= 1'b0;
        end else begin
            to_q <= 1'b0;
            if (load_i) begin
                cnt_q <= load_val_i;
                rld_q <= load_val_i;
            end else if (live) begin
                if (act_i) begin
                    cnt_q <= rld_q;
                end else if (tick_i) begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) begin
                        to_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign count_o   = cnt_q;
    assign timeout_o = to_q;

    // R13: disabled counter holds unless the host loads it
    assert_hold_disabled_R13: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(cnt_q));

    // R8: an unforced change is a single step down
    assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_i) && !$past(act_i) && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) - ONE));

    // R9: one-cycle pulse, only with the count at zero
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);
    assert_pulse_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (cnt_q == '0));

    // R10: a host load never ends in a timeout
    assert_load_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !timeout_o);

    // R12: reload coinciding with a tick suppresses expiry
    assert_reload_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (act_i && tick_i) |=> !timeout_o);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdcfg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [BUS_W-1:0] cfg_wdata,
    output logic [BUS_W-1:0] cfg_rdata,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic             kbd_act,
    input  logic             mouse_act,
    output logic             wd_timeout
);

    logic             idx_wr, data_wr;
    logic             open_s, page_ok_s;
    logic [BUS_W-1:0] idx_s, page_s;
    wd_cfg_t          cfg_s;
    logic             load_s;
    logic [CNT_W-1:0] load_val_s, count_s;
    logic             tick_s, act_s;

    assign idx_wr  = cfg_wr && !cfg_sel;
    assign data_wr = cfg_wr &&  cfg_sel;

    wdcfg_keylock u_lock (
        .clk       (clk),
        .rst       (rst),
        .idx_wr_i  (idx_wr),
        .data_wr_i (data_wr),
        .wdata_i   (cfg_wdata),
        .open_o    (open_s),
        .idx_o     (idx_s),
        .page_o    (page_s),
        .page_ok_o (page_ok_s)
    );

    wdcfg_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .open_i     (open_s),
        .page_ok_i  (page_ok_s),
        .idx_i      (idx_s),
        .page_i     (page_s),
        .data_wr_i  (data_wr),
        .wdata_i    (cfg_wdata),
        .count_i    (count_s),
        .cfg_o      (cfg_s),
        .load_o     (load_s),
        .load_val_o (load_val_s),
        .rdata_o    (cfg_rdata)
    );

    assign tick_s = pick_tick(cfg_s, tick_sec, tick_min);
    assign act_s  = act_hit(cfg_s, kbd_act, mouse_act);

    wdcfg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en_i       (cfg_s.enable),
        .tick_i     (tick_s),
        .act_i      (act_s),
        .load_i     (load_s),
        .load_val_i (load_val_s),
        .count_o    (count_s),
        .timeout_o  (wd_timeout)
    );

endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tick_sec = 1'b0, tick_min = 1'b0, kbd_act = 1'b0, mouse_act = 1'b0;
    logic       wd_timeout;

    int checks = 0;
    int errors = 0;
    int to_seen = 0;
    int to0;

    always #5 clk = ~clk;

    keyed_wdog i_keyed_wdog (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tick_sec(tick_sec), .tick_min(tick_min),
        .kbd_act(kbd_act), .mouse_act(mouse_act), .wd_timeout(wd_timeout)
    );

    always @(negedge clk) if (!rst && wd_timeout) to_seen++;

    localparam logic [1:0] OP_IDX = 2'd0, OP_DAT = 2'd1, OP_CHK = 2'd2;
    localparam int NV = 38;
    // {requirement, op, value}
    localparam logic [13:0] VEC [NV] = '{
        {4'd1,  OP_CHK, 8'hFF},  // R1 shut after reset
        {4'd4,  OP_DAT, 8'h01},  // R4 write while shut
        {4'd2,  OP_IDX, 8'h87},
        {4'd2,  OP_IDX, 8'h30},  // R2 breaks the key
        {4'd2,  OP_IDX, 8'h87},
        {4'd2,  OP_CHK, 8'hFF},  // R2 still shut
        {4'd2,  OP_IDX, 8'h87},  // R2 second consecutive key
        {4'd5,  OP_IDX, 8'h07},
        {4'd1,  OP_CHK, 8'h00},  // R1 page reset value
        {4'd5,  OP_IDX, 8'h30},
        {4'd5,  OP_CHK, 8'h00},  // R5 wrong page reads zero
        {4'd5,  OP_DAT, 8'h01},  // R5 ignored
        {4'd5,  OP_IDX, 8'h07},
        {4'd5,  OP_DAT, 8'h08},
        {4'd5,  OP_CHK, 8'h08},  // R5 page readback
        {4'd5,  OP_IDX, 8'h30},
        {4'd4,  OP_CHK, 8'h00},  // R4 R5 earlier writes had no effect
        {4'd6,  OP_DAT, 8'h01},
        {4'd6,  OP_CHK, 8'h01},  // R6
        {4'd7,  OP_IDX, 8'hF5},
        {4'd7,  OP_DAT, 8'hFF},
        {4'd7,  OP_CHK, 8'h08},  // R7 only bit 3
        {4'd7,  OP_DAT, 8'h00},
        {4'd7,  OP_CHK, 8'h00},
        {4'd8,  OP_IDX, 8'hF6},
        {4'd8,  OP_DAT, 8'h05},
        {4'd8,  OP_CHK, 8'h05},  // R8 load
        {4'd11, OP_IDX, 8'hF7},
        {4'd11, OP_DAT, 8'hFF},
        {4'd11, OP_CHK, 8'hC0},  // R11 bits 6 and 7
        {4'd11, OP_DAT, 8'h00},
        {4'd3,  OP_IDX, 8'hAA},
        {4'd3,  OP_CHK, 8'hFF},  // R3 shut again
        {4'd3,  OP_DAT, 8'h00},  // R3 ignored while shut
        {4'd3,  OP_IDX, 8'h87},
        {4'd3,  OP_IDX, 8'h87},
        {4'd3,  OP_IDX, 8'h30},
        {4'd3,  OP_CHK, 8'h00}   // R3 page cleared by shut
    };

    task automatic step(input logic wr, input logic sel, input logic [7:0] d,
                        input logic ts, input logic tm, input logic kb, input logic ms);
        @(negedge clk);
        cfg_wr = wr; cfg_sel = sel; cfg_wdata = d;
        tick_sec = ts; tick_min = tm; kbd_act = kb; mouse_act = ms;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
        tick_sec = 1'b0; tick_min = 1'b0; kbd_act = 1'b0; mouse_act = 1'b0;
        #1;
    endtask

    task automatic idx(input logic [7:0] d); step(1'b1, 1'b0, d, 0, 0, 0, 0); endtask
    task automatic dat(input logic [7:0] d); step(1'b1, 1'b1, d, 0, 0, 0, 0); endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", int'(wd_timeout), 0);
        check("R1", int'(cfg_rdata), 8'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [1:0] op;
            logic [7:0] v;
            {rq, op, v} = VEC[i];
            if (op == OP_IDX) idx(v);
            else if (op == OP_DAT) dat(v);
            else check($sformatf("R%0d step %0d", rq, i), int'(cfg_rdata), int'(v));
        end

        // restore page, enable kept across the shut (R3)
        idx(8'h07); dat(8'h08); idx(8'h30);
        check("R3", int'(cfg_rdata), 8'h01);

        // R8 seconds decrement, R7 minute tick ignored in seconds mode
        idx(8'hF6);
        check("R8", int'(cfg_rdata), 8'h05);
        step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0, 0);
        check("R8", int'(cfg_rdata), 8'h03);
        step(0, 0, 0, 0, 1, 0, 0);
        check("R7", int'(cfg_rdata), 8'h03);

        // R9 expiry
        to0 = to_seen;
        step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0, 0);
        check("R9", to_seen - to0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        check("R9", int'(wd_timeout), 1);
        check("R9", int'(cfg_rdata), 8'h00);
        @(negedge clk); #1;
        check("R9", int'(wd_timeout), 0);
        step(0, 0, 0, 1, 0, 0, 0);
        check("R9", to_seen - to0, 1);
        check("R9", int'(cfg_rdata), 8'h00);

        // R7 minutes mode
        idx(8'hF5); dat(8'h08);
        idx(8'hF6); dat(8'h02);
        step(0, 0, 0, 1, 0, 0, 0);
        check("R7", int'(cfg_rdata), 8'h02);
        step(0, 0, 0, 0, 1, 0, 0);
        check("R7", int'(cfg_rdata), 8'h01);

        // R11 activity reloads
        idx(8'hF7); dat(8'h40); idx(8'hF6);
        step(0, 0, 0, 0, 0, 1, 0);
        check("R11", int'(cfg_rdata), 8'h02);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R11", int'(cfg_rdata), 8'h01);
        idx(8'hF7); dat(8'h80); idx(8'hF6);
        step(0, 0, 0, 0, 0, 1, 0);
        check("R11", int'(cfg_rdata), 8'h01);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R11", int'(cfg_rdata), 8'h02);

        // R12 same-cycle priority
        step(0, 0, 0, 0, 1, 0, 0);
        check("R12", int'(cfg_rdata), 8'h01);
        to0 = to_seen;
        step(0, 0, 0, 0, 1, 0, 1);
        check("R12", int'(cfg_rdata), 8'h02);
        @(negedge clk); #1;
        check("R12", to_seen - to0, 0);
        step(1, 1, 8'h07, 0, 1, 0, 1);
        check("R12", int'(cfg_rdata), 8'h07);

        // R10 zero write stops quietly
        to0 = to_seen;
        dat(8'h00);
        step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0, 1);
        check("R10", int'(cfg_rdata), 8'h00);
        check("R10", to_seen - to0, 0);

        // R13 disabled counter holds
        dat(8'h04);
        idx(8'h30); dat(8'h00); idx(8'hF6);
        step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0, 1);
        check("R13", int'(cfg_rdata), 8'h04);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule